// File: doc/BRIEF.md
# Thermal threshold interrupt controller

This block watches an 8-bit temperature code from an on-die sensor and compares it, every clock, against four programmable threshold levels. Each level has a pair of thresholds: an upper one that signals a heating event and a lower one that signals a cooling event. The gap between the two acts as hysteresis. Each event latches a pending bit, and a single interrupt line combines the pending bits that are enabled. A fifth, independent threshold drives a hardware trip output for emergency shutdown. That output works only when it is armed by a control bit.

Software programs the block through a small word-addressed register port with combinational read data. For test, an emulation register can replace the live sensor code with a programmed code, so that every comparison can be exercised without heating the die.

Top module: `therm_irq_ctrl`

## Requirements
- R1: The register map uses `reg_addr` word indices: 0 control, 1 upper-threshold word, 2 lower-threshold word, 3 trip threshold (bits [7:0]), 4 interrupt enable, 5 pending status (read only), 6 clear (write only, reads 0), 7 emulation. Level i takes its upper threshold from bits [8i+7:8i] of word 1 and its lower threshold from the same bits of word 2. Every writable register reads back what was stored.
- R2: A level that is not armed, with its code at or above its upper threshold, sets pending bit i at the next edge and becomes armed. It raises no further upper event until it has been disarmed.
- R3: An armed level whose code is at or below its lower threshold sets pending bit 16+i at the next edge and becomes disarmed.
- R4: Writing a word to address 6 clears every pending bit that is set in that word at the next edge. Pending bits are only set by events, and only bits [3:0] and [19:16] exist.
- R5: When an event and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: Interrupt enable bit layout is the same as status: [3:0] upper, [19:16] lower. `irq` is high exactly one cycle after any bit of (status AND enable) is high.
- R7: Control bit 0 is the core enable. While it is 0, no events occur and all levels are disarmed. Writing control with bit 0 at 0 zeroes the interrupt enable register, and writes to the interrupt enable register are ignored while the core is off.
- R8: `hw_trip` is high one cycle after a cycle in which the core enable, the trip enable (control bit 1) and (code at or above the trip threshold) are all true.
- R9: Emulation register bit 0 enables the override and bits [15:8] hold the code. When enabled, that code replaces `sensor_code` in all comparisons, including the trip comparison.
- R10: After reset every register, the pending status, `irq` and `hw_trip` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sensor_code | input | 8 | Live temperature code from the sensor |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt, registered |
| hw_trip | output | 1 | Hardware trip request, registered |

## Verification
The bench first drives directed code sweeps through each level: a crossing upward, a plateau above the upper threshold, a dip that stays above the lower threshold, and a drop to the lower threshold exactly. These separate a correct one-shot armed state from a level compare that retriggers, and inclusive compares from strict ones. A collision of a clear write with a new event checks the priority between them. The emulation override pins the code high while the live input is low, and trip runs with the trip enable off and then on, which separates gating by the enable from a bare compare. Random codes mixed with random register traffic are then checked cycle by cycle against a model in the bench. This covers overlapping thresholds, enable toggles and core shutdown.

// File: rtl/therm_pkg.sv
package therm_pkg;
  localparam int CODE_W   = 8;
  localparam int N_LVL    = 4;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int FALL_OFS = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_UPPER = 3'd1,
    A_LOWER = 3'd2,
    A_TRIP  = 3'd3,
    A_INTEN = 3'd4,
    A_STAT  = 3'd5,
    A_CLR   = 3'd6,
    A_EMUL  = 3'd7
  } addr_e;

  // bits that exist in status / enable: upper events low, lower events at FALL_OFS
  function automatic logic [DATA_W-1:0] valid_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_LVL; i++) begin
      m[i]            = 1'b1;
      m[FALL_OFS + i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [CODE_W-1:0] pick_code(input logic emu_on,
                                                  input logic [CODE_W-1:0] emu_code,
                                                  input logic [CODE_W-1:0] live);
    return emu_on ? emu_code : live;
  endfunction
endpackage

// File: rtl/therm_lvl_det.sv
module therm_lvl_det
  import therm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_en,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] up_th,
  input  logic [CODE_W-1:0] dn_th,
  output logic              up_evt,
  output logic              dn_evt
);
  logic armed;

  always_comb begin
    up_evt = core_en && !armed && (code >= up_th);
    dn_evt = core_en &&  armed && (code <= dn_th);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (!core_en) armed <= 1'b0;
    else if (up_evt)   armed <= 1'b1;
    else if (dn_evt)   armed <= 1'b0;
  end
endmodule

// File: rtl/therm_regs.sv
module therm_regs
  import therm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status,
  output logic              core_en,
  output logic              trip_en,
  output logic [DATA_W-1:0] up_word,
  output logic [DATA_W-1:0] dn_word,
  output logic [CODE_W-1:0] trip_th,
  output logic [DATA_W-1:0] int_en,
  output logic              emu_on,
  output logic [CODE_W-1:0] emu_code,
  output logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] VMASK = valid_mask();
  localparam int EMU_LSB = 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en  <= 1'b0;
      trip_en  <= 1'b0;
      up_word  <= '0;
      dn_word  <= '0;
      trip_th  <= '0;
      int_en   <= '0;
      emu_on   <= 1'b0;
      emu_code <= '0;
    end else if (wr_en) begin
      case (addr_e'(addr))
        A_CTRL: begin
          core_en <= wdata[0];
          trip_en <= wdata[1];
          if (!wdata[0]) int_en <= '0;
        end
        A_UPPER: up_word <= wdata;
        A_LOWER: dn_word <= wdata;
        A_TRIP:  trip_th <= wdata[CODE_W-1:0];
        A_INTEN: if (core_en) int_en <= wdata & VMASK;
        A_EMUL: begin
          emu_on   <= wdata[0];
          emu_code <= wdata[EMU_LSB +: CODE_W];
        end
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr_en && addr == A_CLR) ? (wdata & VMASK) : '0;

  always_comb begin
    rdata = '0;
    case (addr_e'(addr))
      A_CTRL:  rdata[1:0] = {trip_en, core_en};
      A_UPPER: rdata = up_word;
      A_LOWER: rdata = dn_word;
      A_TRIP:  rdata[CODE_W-1:0] = trip_th;
      A_INTEN: rdata = int_en;
      A_STAT:  rdata = status;
      A_EMUL: begin
        rdata[0] = emu_on;
        rdata[EMU_LSB +: CODE_W] = emu_code;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/therm_status.sv
module therm_status
  import therm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_vec,
  input  logic [DATA_W-1:0] clr_vec,
  input  logic [DATA_W-1:0] int_en,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_vec) | evt_vec;  // new event wins
      irq    <= |(status & int_en);
    end
  end
endmodule

// File: rtl/therm_irq_ctrl.sv
module therm_irq_ctrl
  import therm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sensor_code,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              hw_trip
);
  logic              core_en, trip_en, emu_on;
  logic [DATA_W-1:0] up_word, dn_word, int_en, clr_vec, status, evt_vec;
  logic [CODE_W-1:0] trip_th, emu_code, eff_code;
  logic [N_LVL-1:0]  up_evt, dn_evt;
  logic              trip_hit;

  therm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .core_en(core_en), .trip_en(trip_en), .up_word(up_word),
    .dn_word(dn_word), .trip_th(trip_th), .int_en(int_en), .emu_on(emu_on),
    .emu_code(emu_code), .clr_vec(clr_vec), .rdata(reg_rdata)
  );

  assign eff_code = pick_code(emu_on, emu_code, sensor_code);

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    therm_lvl_det u_det (
      .clk(clk), .rst_n(rst_n), .core_en(core_en), .code(eff_code),
      .up_th(up_word[g*CODE_W +: CODE_W]), .dn_th(dn_word[g*CODE_W +: CODE_W]),
      .up_evt(up_evt[g]), .dn_evt(dn_evt[g])
    );
  end

  always_comb begin
    evt_vec = '0;
    evt_vec[N_LVL-1:0]         = up_evt;
    evt_vec[FALL_OFS +: N_LVL] = dn_evt;
  end

  therm_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .clr_vec(clr_vec),
    .int_en(int_en), .status(status), .irq(irq)
  );

  assign trip_hit = core_en && trip_en && (eff_code >= trip_th);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_trip <= 1'b0;
    else        hw_trip <= trip_hit;
  end
endmodule

// File: rtl/therm_irq_ctrl_chk.sv
module therm_irq_ctrl_chk
  import therm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              core_en,
  input logic              trip_en,
  input logic [DATA_W-1:0] int_en,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] evt_vec,
  input logic [DATA_W-1:0] clr_vec,
  input logic [N_LVL-1:0]  up_evt,
  input logic              irq,
  input logic              hw_trip
);
  p_irq_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status & int_en))));

  p_en_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> (int_en == '0));

  p_trip_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_trip |-> $past(core_en && trip_en));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_vec & ~evt_vec)) == '0));

  p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(evt_vec)) == $past(evt_vec)));

  p_up_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((up_evt & $past(up_evt)) == '0));
endmodule

bind therm_irq_ctrl therm_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .trip_en(trip_en), .int_en(int_en),
  .status(status), .evt_vec(evt_vec), .clr_vec(clr_vec), .up_evt(up_evt),
  .irq(irq), .hw_trip(hw_trip)
);

// File: tb/therm_irq_ctrl_tb.sv
`timescale 1ns/1ps
module therm_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sensor_code = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, hw_trip;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [31:0] VM = 32'h000F_000F;

  always #2.5 clk = ~clk;

  therm_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sensor_code(sensor_code), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .hw_trip(hw_trip)
  );

  // bench model
  logic        m_core, m_ten, m_emu;
  logic [31:0] m_up, m_dn, m_en, m_st;
  logic [7:0]  m_trip, m_ecode;
  logic [3:0]  m_arm;
  logic        m_irq, m_hw;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {30'b0, m_ten, m_core};
      3'd1: return m_up;
      3'd2: return m_dn;
      3'd3: return {24'b0, m_trip};
      3'd4: return m_en;
      3'd5: return m_st;
      3'd7: return {16'b0, m_ecode, 7'b0, m_emu};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic [7:0] sens, input string req);
    logic [7:0]  eff;
    logic [31:0] evt, clr, nst;
    logic [3:0]  narm;
    logic        nirq, nhw;
    reg_wr = we; reg_addr = a; reg_wdata = d; sensor_code = sens;
    eff = m_emu ? m_ecode : sens;
    evt = '0; narm = m_arm;
    for (int i = 0; i < 4; i++) begin
      if (!m_core) narm[i] = 1'b0;
      else if (!m_arm[i] && eff >= m_up[8*i +: 8]) begin narm[i] = 1'b1; evt[i] = 1'b1; end
      else if (m_arm[i] && eff <= m_dn[8*i +: 8]) begin narm[i] = 1'b0; evt[16+i] = 1'b1; end
    end
    clr  = (we && a == 3'd6) ? (d & VM) : '0;
    nst  = (m_st & ~clr) | evt;
    nirq = |(m_st & m_en);
    nhw  = m_core && m_ten && (eff >= m_trip);
    if (we) begin
      case (a)
        3'd0: begin m_core = d[0]; m_ten = d[1]; if (!d[0]) m_en = '0; end
        3'd1: m_up = d;
        3'd2: m_dn = d;
        3'd3: m_trip = d[7:0];
        3'd4: if (m_core) m_en = d & VM;
        3'd7: begin m_emu = d[0]; m_ecode = d[15:8]; end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    m_st = nst; m_arm = narm; m_irq = nirq; m_hw = nhw;
    chk("R6", "irq", {31'b0, irq}, {31'b0, m_irq});
    chk("R8", "hw_trip", {31'b0, hw_trip}, {31'b0, m_hw});
    reg_wr = 1'b0;
    #0.1;
    chk(req, $sformatf("rdata@%0d", a), reg_rdata, m_read(a));
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] sens, input string req);
    step(1'b0, a, 32'h0, sens, req);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    m_core = 0; m_ten = 0; m_emu = 0; m_up = 0; m_dn = 0; m_en = 0; m_st = 0;
    m_trip = 0; m_ecode = 0; m_arm = 0; m_irq = 0; m_hw = 0;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state of all registers and outputs
    for (int a = 0; a < 8; a++) rd(3'(a), 8'd0, "R10");

    // R1: threshold packing and readback
    step(1, 3'd1, {8'd200, 8'd150, 8'd100, 8'd50}, 8'd0, "R1");
    step(1, 3'd2, {8'd190, 8'd140, 8'd90, 8'd40}, 8'd0, "R1");
    rd(3'd1, 8'd0, "R1");
    rd(3'd2, 8'd0, "R1");
    step(1, 3'd0, 32'h1, 8'd0, "R7");
    step(1, 3'd4, 32'hFFFF_FFFF, 8'd0, "R6");

    // R2: upward crossing of level 0 at threshold exactly, then plateau
    rd(3'd5, 8'd49, "R2");
    rd(3'd5, 8'd50, "R2");
    rd(3'd5, 8'd70, "R2");
    step(1, 3'd6, 32'h1, 8'd70, "R4");
    rd(3'd5, 8'd70, "R2");     // no retrigger while armed
    // R3: dip above lower threshold, then reach it
    rd(3'd5, 8'd41, "R3");
    rd(3'd5, 8'd40, "R3");
    step(1, 3'd6, 32'hFFFF_FFFF, 8'd40, "R4");
    rd(3'd5, 8'd40, "R4");
    // R5: new upper event collides with a clear of the same bit
    rd(3'd5, 8'd60, "R5");     // sets bit0
    rd(3'd5, 8'd30, "R5");     // sets bit16
    step(1, 3'd6, 32'h0001_0001, 8'd60, "R5");
    rd(3'd5, 8'd60, "R5");

    // R9: emulation overrides a low live code
    step(1, 3'd6, 32'hFFFF_FFFF, 8'd0, "R4");
    step(1, 3'd7, {16'd0, 8'd255, 8'd1}, 8'd0, "R9");
    rd(3'd5, 8'd0, "R9");
    rd(3'd5, 8'd0, "R9");
    step(1, 3'd7, 32'h0, 8'd0, "R9");
    rd(3'd5, 8'd0, "R9");

    // R8: trip gated by trip enable
    step(1, 3'd3, 32'd120, 8'd130, "R8");
    rd(3'd0, 8'd130, "R8");
    step(1, 3'd0, 32'h3, 8'd130, "R8");
    rd(3'd0, 8'd130, "R8");
    rd(3'd0, 8'd119, "R8");

    // R7: core off zeroes enables, ignores enable writes, stops events
    step(1, 3'd6, 32'hFFFF_FFFF, 8'd0, "R4");
    step(1, 3'd0, 32'h2, 8'd0, "R7");
    rd(3'd4, 8'd0, "R7");
    step(1, 3'd4, 32'hFFFF_FFFF, 8'd0, "R7");
    rd(3'd4, 8'd255, "R7");
    rd(3'd5, 8'd255, "R7");
    step(1, 3'd0, 32'h1, 8'd0, "R7");
    step(1, 3'd4, 32'h000F_000F, 8'd0, "R6");

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [2:0]  a;
      logic [31:0] d;
      logic        we;
      a  = 3'($urandom % 8);
      we = ($urandom % 6) == 0;
      d  = $urandom;
      if (a == 3'd0) d[0] = ($urandom % 8) != 0;
      if (a == 3'd7) d[0] = ($urandom % 4) == 0;
      if (!we) a = 3'd5;
      step(we, a, d, 8'($urandom), (a == 3'd5) ? "R3" : "R1");
    end

    done = 1;
    finish_up();
  end
endmodule